// File: doc/BRIEF.md
# Packet Admission Read Arbiter

This block decides, cycle by cycle, whether the next word of a stored packet may be pulled from an input packet FIFO and pushed into a fixed-latency processing pipeline whose results land in an output FIFO. Each FIFO word carries one byte. The output FIFO must never receive more words than it can hold. Because words already released are still travelling through the pipeline, the admission rule reserves room for them.

Two policies are available through a mode input. In whole-packet mode a packet is started only when the free room in the output FIFO is strictly larger than the packet length plus the pipeline latency. Once started, the packet streams without a gap until its last word. In word-by-word mode one word is read in every cycle in which the output FIFO's almost-full flag is low and a word is present. The almost-full threshold is assumed to reserve at least the pipeline length, and packets may then arrive downstream with gaps. The mode is taken only at a packet boundary. A read request becomes a word-valid strobe after the input FIFO's read latency.

Top module: `pkt_admit_arb`

## Requirements
- R1: While `rst_n` is low, `rd_req` and `word_vld` are 0. After reset the arbiter is between packets.
- R2: In whole-packet mode, between packets, `rd_req` rises only if `head_present` is 1 and free room is strictly greater than `head_len + PIPE_LAT`. Free room is `FIFO_DEPTH - out_used`, floored at 0 when `out_used >= FIFO_DEPTH`.
- R3: In whole-packet mode, once the first word of a packet is read, `rd_req` stays 1 in every cycle up to and including the read of the word with `head_last = 1`. This holds whatever `out_afull`, `out_used` and `head_present` do.
- R4: In whole-packet mode, between packets, when the R2 condition is false no word is read and the arbiter keeps waiting.
- R5: In word-by-word mode, `rd_req` equals `head_present AND NOT out_afull` in every cycle.
- R6: In word-by-word mode, a packet may be interrupted. `out_afull = 1` in the middle of a packet stops reads, and reads resume when it returns to 0.
- R7: `mode_whole` (1 = whole-packet, 0 = word-by-word) is sampled when the first word of a packet is read. A change while a packet is in progress has no effect until the next packet.
- R8: `word_vld` equals `rd_req` delayed by `RD_LAT` clock cycles.
- R9: A read with `head_last = 1` ends the packet. A one-word packet returns the arbiter to the between-packets state, and the next packet may start in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_whole | input | 1 | Policy select: 1 whole-packet, 0 word-by-word |
| head_present | input | 1 | Input FIFO holds a word or packet ready to read |
| head_len | input | LEN_W | Length in words of the packet at the input FIFO head |
| head_last | input | 1 | The word being read is the last of its packet |
| out_used | input | CNT_W | Used-word count of the output FIFO |
| out_afull | input | 1 | Almost-full flag of the output FIFO |
| rd_req | output | 1 | Read request to the input FIFO |
| word_vld | output | 1 | Word-valid strobe into the pipeline |

## Verification
On every cycle, the assertions check four things. A whole-packet start happens only with a fitting packet present. A started whole packet never pauses. Word-by-word reads never occur while almost-full is high. The latched mode and the packet-state transitions follow the last-word flag. Only the bench scenarios can show the exact arithmetic boundary of the space test, including the saturation of free room when the used count exceeds the depth. The same holds for the effect of mode changes in the middle of a packet, and for back-to-back single-word packets. Those scenarios sweep every used count and length of a small configuration against a value computed in the bench.

// File: rtl/pkt_admit_pkg.sv
// Package: shared types for the packet admission arbiter.
// Assumes: nothing beyond a single clock domain.
package pkt_admit_pkg;

    // Admission policy; the encoding matches the mode_whole input bit.
    typedef enum logic {
        MODE_WORD  = 1'b0,
        MODE_WHOLE = 1'b1
    } admit_mode_e;

endpackage : pkt_admit_pkg

// File: rtl/admit_space_chk.sv
// Module: admit_space_chk
// Compares the free room of the output FIFO with the head packet length
// plus the pipeline latency margin. Purely combinational.
// Assumes: one FIFO word per byte; a used count above DEPTH means full.
module admit_space_chk #(
    parameter int DEPTH = 2048,
    parameter int LAT   = 10,
    parameter int LEN_W = 11,
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] used_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             fits_o
);

    localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 2;
    localparam logic [SUM_W-1:0] DEPTH_X = SUM_W'(DEPTH);
    localparam logic [SUM_W-1:0] LAT_X   = SUM_W'(LAT);

    logic [SUM_W-1:0] used_x;
    logic [SUM_W-1:0] free_x;
    logic [SUM_W-1:0] need_x;

    assign used_x = SUM_W'(used_i);

    // Free room, floored at zero when the count reaches or passes the depth.
    always_comb begin
        if (used_x >= DEPTH_X) begin
            free_x = '0;
        end else begin
            free_x = DEPTH_X - used_x;
        end
    end

    // Room required: the packet itself plus the words in flight.
    assign need_x = SUM_W'(len_i) + LAT_X;

    assign fits_o = (free_x > need_x);

endmodule : admit_space_chk

// File: rtl/admit_pkt_track.sv
// Module: admit_pkt_track
// Tracks whether a packet is in progress and holds the policy latched
// at its first word. State changes only on an actual read.
// Assumes: head_last_i is valid in every cycle in which rd_i is high.
module admit_pkt_track
    import pkt_admit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_i,
    input  logic        head_last_i,
    input  admit_mode_e mode_i,
    output logic        in_pkt_o,
    output admit_mode_e mode_q_o
);

    // In-packet flag: set by a non-last read, cleared by a last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_o <= 1'b0;
        end else if (rd_i) begin
            in_pkt_o <= !head_last_i;
        end
    end

    // Policy latch: captured only on the first read of a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q_o <= MODE_WORD;
        end else if (rd_i && !in_pkt_o) begin
            mode_q_o <= mode_i;
        end
    end

    // R7: the latched policy cannot move while a packet continues.
    p_mode_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt_o && $past(in_pkt_o)) |-> $stable(mode_q_o));

    // R9: a read of the last word ends the packet on the next cycle.
    p_last_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && head_last_i) |=> !in_pkt_o);

    // R9: a read of a non-last word leaves a packet open.
    p_mid_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !head_last_i) |=> in_pkt_o);

endmodule : admit_pkt_track

// File: rtl/admit_vld_pipe.sv
// Module: admit_vld_pipe
// Delays the read request by the input FIFO read latency to form the
// word-valid strobe for the first pipeline stage.
// Assumes: RD_LAT >= 1.
module admit_vld_pipe #(
    parameter int RD_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    output logic vld_o
);

    logic [RD_LAT-1:0] stage_q;

    generate
        if (RD_LAT == 1) begin : g_single
            // One-stage delay of the read request.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= rd_i;
                end
            end
        end else begin : g_multi
            // Multi-stage shift of the read request.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= {stage_q[RD_LAT-2:0], rd_i};
                end
            end
        end
    endgenerate

    assign vld_o = stage_q[RD_LAT-1];

endmodule : admit_vld_pipe

// File: rtl/pkt_admit_arb.sv
// Module: pkt_admit_arb (top)
// Read arbiter between an input packet FIFO and a fixed-latency pipeline
// feeding an output FIFO. Whole-packet mode reserves room for the packet
// plus PIPE_LAT in-flight words; word-by-word mode gates each read on the
// output almost-full flag.
// Assumes: in whole-packet mode the complete packet already sits in the
// input FIFO; FIFO_DEPTH is at least one maximum packet plus PIPE_LAT;
// the almost-full threshold reserves at least PIPE_LAT words.
module pkt_admit_arb
    import pkt_admit_pkg::*;
#(
    parameter int FIFO_DEPTH = 2048,
    parameter int PIPE_LAT   = 10,
    parameter int MAX_LEN    = 1518,
    parameter int RD_LAT     = 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_whole,
    input  logic             head_present,
    input  logic [LEN_W-1:0] head_len,
    input  logic             head_last,
    input  logic [CNT_W-1:0] out_used,
    input  logic             out_afull,
    output logic             rd_req,
    output logic             word_vld
);

    logic        fits;
    logic        in_pkt;
    admit_mode_e mode_q;
    admit_mode_e mode_in;
    admit_mode_e act_mode;

    assign mode_in = admit_mode_e'(mode_whole);

    admit_space_chk #(
        .DEPTH (FIFO_DEPTH),
        .LAT   (PIPE_LAT),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) space_i (
        .used_i (out_used),
        .len_i  (head_len),
        .fits_o (fits)
    );

    admit_pkt_track track_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (rd_req),
        .head_last_i (head_last),
        .mode_i      (mode_in),
        .in_pkt_o    (in_pkt),
        .mode_q_o    (mode_q)
    );

    admit_vld_pipe #(
        .RD_LAT (RD_LAT)
    ) vld_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_i  (rd_req),
        .vld_o (word_vld)
    );

    // Policy in force: latched inside a packet, live at a boundary.
    assign act_mode = in_pkt ? mode_q : mode_in;

    // Read request per policy, forced low during reset.
    always_comb begin
        rd_req = 1'b0;
        if (rst_n) begin
            if (act_mode == MODE_WHOLE) begin
                rd_req = in_pkt || (head_present && fits);
            end else begin
                rd_req = head_present && !out_afull;
            end
        end
    end

    // R2: a whole-packet start needs a present packet that fits.
    p_start_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_pkt && mode_whole) |-> (fits && head_present));

    // R3: a whole packet in progress never pauses.
    p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt && mode_q == MODE_WHOLE) |-> rd_req);

    // R4: no read between packets in whole mode without room.
    p_wait_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_pkt && mode_whole && !fits) |-> !rd_req);

    // R5 / R6: word mode never reads while almost-full is high.
    p_afull_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == MODE_WORD && out_afull) |-> !rd_req);

    // R8: for a one-cycle read latency, valid trails the request.
    generate
        if (RD_LAT == 1) begin : g_vld_chk
            p_vld_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
                word_vld == $past(rd_req));
        end
    endgenerate

endmodule : pkt_admit_arb

// File: tb/pkt_admit_arb_tb_top.sv
`timescale 1ns/1ps
// Bench: small configuration, exhaustive sweep of the whole-packet space
// test plus directed packet scenarios, with expected values computed here.
module pkt_admit_arb_tb_top;

    localparam int DEPTH = 32;
    localparam int LAT   = 4;
    localparam int MAXL  = 15;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int LW    = $clog2(MAXL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_whole = 1'b0;
    logic          head_present = 1'b0;
    logic [LW-1:0] head_len = '0;
    logic          head_last = 1'b1;
    logic [CW-1:0] out_used = '0;
    logic          out_afull = 1'b0;
    logic          rd_req;
    logic          word_vld;

    int total = 0;
    int bad   = 0;
    logic armed = 1'b0;
    logic prev_rd = 1'b0;

    always #2.5 clk = ~clk;

    pkt_admit_arb #(
        .FIFO_DEPTH (DEPTH),
        .PIPE_LAT   (LAT),
        .MAX_LEN    (MAXL),
        .RD_LAT     (1)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_whole   (mode_whole),
        .head_present (head_present),
        .head_len     (head_len),
        .head_last    (head_last),
        .out_used     (out_used),
        .out_afull    (out_afull),
        .rd_req       (rd_req),
        .word_vld     (word_vld)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // R8: mid-cycle monitor, valid must equal the previous cycle's request.
    always @(negedge clk) begin
        if (rst_n) begin
            if (armed) begin
                chk("R8 word_vld vs prior rd_req", word_vld, prev_rd);
            end
            armed   <= 1'b1;
            prev_rd <= rd_req;
        end
    end

    initial begin
        #(100000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset with inputs that would otherwise read.
        head_present = 1'b1;
        repeat (3) tick();
        chk("R1 rd_req in reset", rd_req, 1'b0);
        chk("R1 word_vld in reset", word_vld, 1'b0);
        rst_n = 1'b1;
        mode_whole = 1'b1;
        out_used = CW'(DEPTH);
        #1;
        chk("R1 idle after reset", rd_req, 1'b0);
        tick();

        // R2 / R4: exhaustive sweep of used count, length and presence.
        head_last = 1'b1;
        for (int u = 0; u <= DEPTH + 8; u++) begin
            for (int l = 1; l <= MAXL; l++) begin
                for (int p = 0; p < 2; p++) begin
                    int  fr;
                    logic ex;
                    fr = (u >= DEPTH) ? 0 : DEPTH - u;
                    ex = (p == 1) && (fr > l + LAT);
                    out_used = CW'(u);
                    head_len = LW'(l);
                    head_present = p[0];
                    #1;
                    chk(ex ? "R2 start" : "R4 wait", rd_req, ex);
                    tick();
                end
            end
        end

        // R2: named boundary, free room equal to need versus one more.
        head_present = 1'b1;
        head_len = LW'(5);
        out_used = CW'(DEPTH - 9);
        #1;
        chk("R2 free equals need", rd_req, 1'b0);
        tick();
        out_used = CW'(DEPTH - 10);
        #1;
        chk("R2 free exceeds need", rd_req, 1'b1);
        tick();

        // R3: five-word whole packet, hostile inputs mid-packet.
        out_used = '0;
        head_len = LW'(5);
        head_last = 1'b0;
        #1;
        chk("R3 start", rd_req, 1'b1);
        for (int k = 1; k <= 4; k++) begin
            tick();
            out_afull = 1'b1;
            out_used = CW'(DEPTH + 8);
            head_present = 1'b0;
            head_last = (k == 4);
            #1;
            chk("R3 hold mid-packet", rd_req, 1'b1);
        end
        tick();
        head_present = 1'b1;
        #1;
        chk("R4 stop after last word", rd_req, 1'b0);
        tick();

        // R7: whole packet survives a switch to word mode.
        out_afull = 1'b0;
        out_used = '0;
        head_len = LW'(3);
        head_last = 1'b0;
        #1;
        chk("R7 whole start", rd_req, 1'b1);
        tick();
        mode_whole = 1'b0;
        out_afull = 1'b1;
        #1;
        chk("R7 whole kept after switch", rd_req, 1'b1);
        tick();
        head_last = 1'b1;
        #1;
        chk("R7 whole last word", rd_req, 1'b1);
        tick();
        #1;
        chk("R5 word mode at boundary afull", rd_req, 1'b0);
        tick();

        // R7: word packet ignores a switch to whole mode.
        out_afull = 1'b0;
        head_last = 1'b0;
        #1;
        chk("R7 word start", rd_req, 1'b1);
        tick();
        mode_whole = 1'b1;
        out_afull = 1'b1;
        #1;
        chk("R7 word kept after switch", rd_req, 1'b0);
        tick();
        out_afull = 1'b0;
        head_last = 1'b1;
        #1;
        chk("R6 resume after stall", rd_req, 1'b1);
        tick();
        out_used = CW'(DEPTH);
        #1;
        chk("R7 whole policy at boundary", rd_req, 1'b0);
        tick();

        // R6: word mode stalls in the middle of a packet.
        mode_whole = 1'b0;
        out_used = '0;
        head_last = 1'b0;
        for (int s = 0; s < 6; s++) begin
            logic af;
            af = (s == 1) || (s == 2) || (s == 4);
            out_afull = af;
            #1;
            chk("R6 mid-packet gate", rd_req, !af);
            tick();
        end
        head_last = 1'b1;
        out_afull = 1'b0;
        #1;
        chk("R6 close packet", rd_req, 1'b1);
        tick();

        // R5: all flag combinations between packets.
        for (int c = 0; c < 4; c++) begin
            head_present = c[0];
            out_afull = c[1];
            #1;
            chk("R5 word gate", rd_req, c[0] && !c[1]);
            tick();
        end

        // R9: back-to-back single-word whole packets.
        mode_whole = 1'b1;
        head_present = 1'b1;
        out_afull = 1'b0;
        out_used = '0;
        head_len = LW'(1);
        head_last = 1'b1;
        #1;
        chk("R9 first single word", rd_req, 1'b1);
        tick();
        chk("R9 next single word", rd_req, 1'b1);
        head_present = 1'b0;
        tick();
        #1;
        chk("R9 idle after singles", rd_req, 1'b0);
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule : pkt_admit_arb_tb_top